// File: doc/BRIEF.md
# Outbound Descriptor Bypass Selector

This block sits in the outbound request path of a PCIe controller and decides, for each request, whether normal address translation is skipped. It skips translation when the upper part of the request's 12-bit virtual ID equals a programmed match value and the request's address-select value is nonzero. In that case, the packet attributes come from one of 32 programmable descriptors, chosen by the low virtual-ID bits.

On a bypass, the block returns a 3-bit traffic class and a 16-bit requester ID. The requester ID is assembled from the chosen descriptor or from the bus and device numbers that the link captured. Which source is used depends on a per-descriptor enable bit and on whether the link runs in ARI or legacy numbering. A small register port writes the match value and the descriptor table and reads them back.

Top module: `obd_bypass_sel`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_bypass` are 0, the match register reads 0, and every descriptor reads 0.
- R2: The match register is at byte address 0x80. A write stores only `cfg_wdata[11:5]`, and a read returns that value in bits 11:5 with every other bit 0. Writes to addresses outside 0x00–0x80 have no effect.
- R3: Descriptor k is at byte address 4·k, for k = 0..31. It keeps traffic class bits 31:29, enable bit 16, bus field 15:8 and device/function field 7:0, and it reads 0 in bits 28:17. Unmapped addresses read 0.
- R4: A bypass is reported exactly when `req_vid[11:5]` equals the stored match value and `req_asel` is nonzero.
- R5: When `req_asel` is 0, no bypass is reported, even if the virtual ID matches.
- R6: When no bypass is reported, `rsp_tc` and `rsp_rid` are 0.
- R7: On a bypass, the descriptor used is the one indexed by `req_vid[4:0]`, and `rsp_tc` equals its bits 31:29.
- R8: In legacy mode (`req_ari` = 0) with enable = 1, `rsp_rid` is {descriptor bus, 1'b0, descriptor bits 7:4, descriptor bits 2:0}.
- R9: In legacy mode with enable = 0, `rsp_rid` is {`cap_bus`, `cap_dev`, descriptor bits 2:0}. The descriptor's bus field and bits 7:4 have no effect.
- R10: In ARI mode (`req_ari` = 1), `rsp_rid[7:0]` equals descriptor bits 7:0. `rsp_rid[15:8]` is the descriptor bus field when enable = 1 and `cap_bus` when enable = 0.
- R11: Results are registered. `rsp_valid` and the result fields appear on the cycle after the cycle in which `req_valid` is sampled high, and `rsp_valid` is 0 on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| req_valid | input | 1 | Request strobe |
| req_vid | input | 12 | Outbound virtual ID |
| req_asel | input | 4 | Address-select value |
| req_ari | input | 1 | 1 = ARI numbering, 0 = legacy |
| cap_bus | input | 8 | Bus number captured by the link |
| cap_dev | input | 5 | Device number captured by the link |
| rsp_valid | output | 1 | Result valid |
| rsp_bypass | output | 1 | Translation bypass flag |
| rsp_tc | output | 3 | Traffic class |
| rsp_rid | output | 16 | Requester ID |

## Verification
The bound checker watches these properties on every cycle:
- the one-cycle response timing;
- the suppression of a bypass when the address select is zero;
- a bypass on every match against the live match register;
- all-zero attribute outputs whenever no bypass is reported;
- zero read-back of the match register's unused bits.

The bench's scenarios cover what the checker cannot see:
- how the requester ID is assembled, since the descriptor enable bit does not reach the ports;
- the choice of descriptor index;
- the masking of descriptor reserved bits;
- that the captured bus and device inputs are ignored when a descriptor supplies them.

// File: rtl/obd_pkg.sv
package obd_pkg;

   localparam int TC_W    = 3;
   localparam int BUS_W   = 8;
   localparam int DEVFN_W = 8;
   localparam int DEV_W   = 5;
   localparam int RID_W   = 16;
   localparam int WORD_W  = 32;

   typedef struct packed {
      logic [TC_W-1:0]    tc;
      logic               en;
      logic [BUS_W-1:0]   bus;
      logic [DEVFN_W-1:0] devfn;
   } desc_t;

   function automatic logic [WORD_W-1:0] desc_pack(desc_t d);
      return {d.tc, 12'b0, d.en, d.bus, d.devfn};
   endfunction

   function automatic desc_t desc_unpack(logic [WORD_W-1:0] w);
      desc_t d;
      d.tc    = w[31:29];
      d.en    = w[16];
      d.bus   = w[15:8];
      d.devfn = w[7:0];
      return d;
   endfunction

endpackage

// File: rtl/obd_cfg_regs.sv
module obd_cfg_regs
   import obd_pkg::*;
#(
   parameter int NUM_DESC  = 32,
   parameter int MATCH_W   = 7,
   parameter int MATCH_LSB = 5,
   parameter int ADDR_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [WORD_W-1:0]   cfg_wdata,
   output logic [WORD_W-1:0]   cfg_rdata,
   output logic [MATCH_W-1:0]  match_val,
   output desc_t               desc_tab [NUM_DESC]
);

   localparam int IDX_W      = ADDR_W - 2;
   localparam int MATCH_WORD = NUM_DESC;

   logic [IDX_W-1:0] widx;
   logic             unused_bits;

   assign widx        = cfg_addr[ADDR_W-1:2];
   assign unused_bits = ^{cfg_addr[1:0], cfg_wdata[28:17]};

   if (MATCH_WORD >= (1 << IDX_W)) begin : g_bad_addr
      $error("obd_cfg_regs: ADDR_W too small for NUM_DESC plus match word");
   end
   if (MATCH_LSB + MATCH_W > WORD_W) begin : g_bad_match
      $error("obd_cfg_regs: match field exceeds register word");
   end

   // match register
   always_ff @(posedge clk) begin
      if (!rst_n)
         match_val <= '0;
      else if (cfg_we && widx == IDX_W'(MATCH_WORD))
         match_val <= cfg_wdata[MATCH_LSB +: MATCH_W];
   end

   // descriptor table, one register per entry
   for (genvar k = 0; k < NUM_DESC; k++) begin : g_desc
      always_ff @(posedge clk) begin
         if (!rst_n)
            desc_tab[k] <= '0;
         else if (cfg_we && widx == IDX_W'(k))
            desc_tab[k] <= desc_unpack(cfg_wdata);
      end
   end

   // read mux
   always_comb begin
      cfg_rdata = '0;
      if (widx == IDX_W'(MATCH_WORD))
         cfg_rdata[MATCH_LSB +: MATCH_W] = match_val;
      for (int k = 0; k < NUM_DESC; k++) begin
         if (widx == IDX_W'(k))
            cfg_rdata = desc_pack(desc_tab[k]);
      end
   end

endmodule

// File: rtl/obd_rid_build.sv
module obd_rid_build
   import obd_pkg::*;
(
   input  desc_t              desc,
   input  logic               ari,
   input  logic [BUS_W-1:0]   cap_bus,
   input  logic [DEV_W-1:0]   cap_dev,
   output logic [TC_W-1:0]    tc,
   output logic [RID_W-1:0]   rid
);

   localparam int FN_W = RID_W - BUS_W - DEV_W;

   logic [BUS_W-1:0]   bus_sel;
   logic [DEV_W-1:0]   dev_sel;
   logic [BUS_W-1:0]   low_legacy;
   logic               unused_fn3;

   assign unused_fn3 = desc.devfn[3];

   if (FN_W != 3) begin : g_bad_layout
      $error("obd_rid_build: legacy function field must be 3 bits");
   end

   assign tc      = desc.tc;
   assign bus_sel = desc.en ? desc.bus : cap_bus;
   assign dev_sel = desc.en ? {1'b0, desc.devfn[7:4]} : cap_dev;

   assign low_legacy = {dev_sel, desc.devfn[FN_W-1:0]};

   always_comb begin
      if (ari)
         rid = {bus_sel, desc.devfn};
      else
         rid = {bus_sel, low_legacy};
   end

endmodule

// File: rtl/obd_bypass_sel.sv
module obd_bypass_sel
   import obd_pkg::*;
#(
   parameter int VID_W    = 12,
   parameter int SEL_W    = 5,
   parameter int ASEL_W   = 4,
   parameter int ADDR_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic               req_valid,
   input  logic [VID_W-1:0]   req_vid,
   input  logic [ASEL_W-1:0]  req_asel,
   input  logic               req_ari,
   input  logic [7:0]         cap_bus,
   input  logic [4:0]         cap_dev,
   output logic               rsp_valid,
   output logic               rsp_bypass,
   output logic [2:0]         rsp_tc,
   output logic [15:0]        rsp_rid
);

   localparam int NUM_DESC = 1 << SEL_W;
   localparam int MATCH_W  = VID_W - SEL_W;

   if (MATCH_W < 1) begin : g_bad_vid
      $error("obd_bypass_sel: VID_W must exceed SEL_W");
   end

   logic [MATCH_W-1:0] match_val;
   desc_t              desc_tab [NUM_DESC];
   desc_t              sel_desc;
   logic               hit;
   logic [TC_W-1:0]    nxt_tc;
   logic [RID_W-1:0]   nxt_rid;

   obd_cfg_regs #(
      .NUM_DESC  (NUM_DESC),
      .MATCH_W   (MATCH_W),
      .MATCH_LSB (SEL_W),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .match_val (match_val),
      .desc_tab  (desc_tab)
   );

   assign sel_desc = desc_tab[req_vid[SEL_W-1:0]];
   assign hit      = (req_vid[VID_W-1:SEL_W] == match_val) && (req_asel != '0);

   obd_rid_build u_rid (
      .desc    (sel_desc),
      .ari     (req_ari),
      .cap_bus (cap_bus),
      .cap_dev (cap_dev),
      .tc      (nxt_tc),
      .rid     (nxt_rid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_bypass <= 1'b0;
         rsp_tc     <= '0;
         rsp_rid    <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid && hit) begin
            rsp_bypass <= 1'b1;
            rsp_tc     <= nxt_tc;
            rsp_rid    <= nxt_rid;
         end else begin
            rsp_bypass <= 1'b0;
            rsp_tc     <= '0;
            rsp_rid    <= '0;
         end
      end
   end

endmodule

// File: rtl/obd_bypass_sel_chk.sv
module obd_bypass_sel_chk #(
   parameter int VID_W  = 12,
   parameter int SEL_W  = 5,
   parameter int ASEL_W = 4,
   parameter int ADDR_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        cfg_addr,
   input logic [31:0]              cfg_rdata,
   input logic                     req_valid,
   input logic [VID_W-1:0]         req_vid,
   input logic [ASEL_W-1:0]        req_asel,
   input logic [VID_W-SEL_W-1:0]   match_val,
   input logic                     rsp_valid,
   input logic                     rsp_bypass,
   input logic [2:0]               rsp_tc,
   input logic [15:0]              rsp_rid
);

   localparam int MATCH_ADDR = (1 << SEL_W) * 4;

   // R11: response appears one cycle after a strobe
   a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R11: no response without a strobe
   a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R5: zero address select never bypasses
   a_r5_asel_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_asel == '0) |=> !rsp_bypass);

   // R4: a match with nonzero select always bypasses
   a_r4_match_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_asel != '0 && req_vid[VID_W-1:SEL_W] == match_val) |=> rsp_bypass);

   // R6: attributes are zero without a bypass
   a_r6_zero_attr: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_bypass |-> (rsp_tc == '0 && rsp_rid == '0));

   // R2: only the match field of the match register reads nonzero
   a_r2_match_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr[ADDR_W-1:2] == (ADDR_W-2)'(MATCH_ADDR/4)) |->
      (cfg_rdata[31:VID_W] == '0 && cfg_rdata[SEL_W-1:0] == '0));

endmodule

bind obd_bypass_sel obd_bypass_sel_chk #(
   .VID_W  (VID_W),
   .SEL_W  (SEL_W),
   .ASEL_W (ASEL_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_addr   (cfg_addr),
   .cfg_rdata  (cfg_rdata),
   .req_valid  (req_valid),
   .req_vid    (req_vid),
   .req_asel   (req_asel),
   .match_val  (match_val),
   .rsp_valid  (rsp_valid),
   .rsp_bypass (rsp_bypass),
   .rsp_tc     (rsp_tc),
   .rsp_rid    (rsp_rid)
);

// File: tb/obd_bypass_sel_tb.sv
module obd_bypass_sel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [11:0] req_vid = '0;
   logic [3:0]  req_asel = '0;
   logic        req_ari = 1'b0;
   logic [7:0]  cap_bus = '0;
   logic [4:0]  cap_dev = '0;
   logic        rsp_valid, rsp_bypass;
   logic [2:0]  rsp_tc;
   logic [15:0] rsp_rid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   obd_bypass_sel dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_vid(req_vid), .req_asel(req_asel), .req_ari(req_ari),
      .cap_bus(cap_bus), .cap_dev(cap_dev), .rsp_valid(rsp_valid),
      .rsp_bypass(rsp_bypass), .rsp_tc(rsp_tc), .rsp_rid(rsp_rid)
   );

   // reference state
   logic [31:0] desc_m [32];
   logic [6:0]  match_m = '0;

   typedef struct {
      logic        byp;
      logic [2:0]  tc;
      logic [15:0] rid;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(logic [11:0] vid, logic [3:0] asel, logic ari,
                                  logic [7:0] bus, logic [4:0] dev, string tag);
      exp_t e;
      logic [31:0] d;
      logic [7:0]  b;
      logic [4:0]  dv;
      e.tag = tag;
      e.byp = (vid[11:5] == match_m) && (asel != 4'd0);
      d = desc_m[vid[4:0]];
      if (!e.byp) begin
         e.tc = '0; e.rid = '0;
      end else begin
         e.tc = d[31:29];
         b  = d[16] ? d[15:8] : bus;
         dv = d[16] ? {1'b0, d[7:4]} : dev;
         e.rid = ari ? {b, d[7:0]} : {b, dv, d[2:0]};
      end
      return e;
   endfunction

   task automatic cfg_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      if (a[7:2] < 6'd32) desc_m[a[6:2]] = d & 32'hE001FFFF;
      else if (a[7:2] == 6'd32) match_m = d[11:5];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      chk(tag, cfg_rdata, exp);
   endtask

   task automatic send(logic [11:0] vid, logic [3:0] asel, logic ari,
                       logic [7:0] bus, logic [4:0] dev, string tag);
      @(negedge clk);
      req_valid = 1'b1; req_vid = vid; req_asel = asel; req_ari = ari;
      cap_bus = bus; cap_dev = dev;
      exp_q.push_back(model(vid, asel, ari, bus, dev, tag));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R11 actual=rsp_valid=1 expected=no response");
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk({e.tag, " bypass"}, {31'b0, rsp_bypass}, {31'b0, e.byp});
               chk({e.tag, " tc"}, {29'b0, rsp_tc}, {29'b0, e.tc});
               chk({e.tag, " rid"}, {16'b0, rsp_rid}, {16'b0, e.rid});
            end
         end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            checks++; errors++;
            $display("FAIL R11 actual=rsp_valid=0 expected=1");
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 32; k++) desc_m[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
      chk("R1 rsp_bypass", {31'b0, rsp_bypass}, 32'h0);
      cfg_read(8'h80, 32'h0, "R1 match reset");
      cfg_read(8'h14, 32'h0, "R1 desc5 reset");

      // R2: only bits 11:5 kept
      cfg_write(8'h80, 32'hFFFF_FFFF);
      cfg_read(8'h80, 32'h0000_0FE0, "R2 match mask");
      cfg_write(8'h80, 32'h55 << 5);
      cfg_read(8'h80, 32'h0000_0AA0, "R2 match value");
      cfg_write(8'h84, 32'hFFFF_FFFF);
      cfg_read(8'h80, 32'h0000_0AA0, "R2 unmapped write ignored");
      cfg_read(8'h84, 32'h0, "R3 unmapped reads zero");

      // R3: descriptor reserved bits
      cfg_write(8'h0C, 32'hFFFF_FFFF);
      cfg_read(8'h0C, 32'hE001_FFFF, "R3 desc3 mask");
      cfg_write(8'h00, 32'h4000_12A5);
      cfg_write(8'h7C, 32'hA001_9C6B);
      cfg_read(8'h7C, 32'hA001_9C6B, "R3 desc31 readback");
      cfg_read(8'h00, 32'h4000_12A5, "R3 desc0 readback");

      // requests
      send({7'h55, 5'd3}, 4'h1, 1'b0, 8'h34, 5'h1B, "R8 legacy en1 desc3");
      send({7'h55, 5'd0}, 4'h2, 1'b0, 8'h34, 5'h1B, "R9 legacy en0 desc0");
      send({7'h55, 5'd31}, 4'hF, 1'b1, 8'h34, 5'h1B, "R10 ari en1 desc31");
      send({7'h55, 5'd0}, 4'h8, 1'b1, 8'h77, 5'h02, "R10 ari en0 desc0");
      send({7'h55, 5'd31}, 4'h3, 1'b0, 8'h11, 5'h1F, "R8 R7 legacy en1 desc31");
      send({7'h55, 5'd3}, 4'h0, 1'b0, 8'h34, 5'h1B, "R5 asel zero");
      send({7'h54, 5'd3}, 4'h1, 1'b0, 8'h34, 5'h1B, "R4 R6 vid mismatch");
      idle(1);
      send({7'h55, 5'd0}, 4'h1, 1'b0, 8'hC3, 5'h05, "R9 capture varies");
      send({7'h55, 5'd7}, 4'h1, 1'b0, 8'h00, 5'h00, "R7 empty desc7");
      idle(3);

      cfg_write(8'h80, 32'h0000_0000);
      send({7'h00, 5'd3}, 4'h4, 1'b1, 8'h00, 5'h00, "R4 new match hit");
      send({7'h55, 5'd3}, 4'h4, 1'b1, 8'h00, 5'h00, "R4 old match miss");
      idle(4);

      chk("R11 queue drained", exp_q.size(), 32'd0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule